// File: doc/BRIEF.md
# Data-Memory Address Generator

This block forms one data-memory address per instruction, separately from the arithmetic datapath. A memory access can then run in the same cycle as a compute operation. A 4-bit operation code selects what the block does. Two operand words come with it: a data word from the register file and an immediate field from the instruction.

The block holds five registers of its own: two pointers (P0 and P1), a stride, and a lower and an upper ring bound for circular buffers. The address can come from the immediate or from the register-file word. It can also be a pointer, either as it stands or with the immediate added. After use, a pointer can advance by the stride, or step by one and wrap to the lower bound when it reaches the upper bound.

The address leaves through a register with a valid flag. Both change one clock edge after the operation is presented with the enable high. While the enable is low, nothing changes.

Top module: `addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, P0, P1, stride, lower bound and upper bound clear to zero, and `addr` and `addr_vld` clear to zero.
- R2: Code 0000 loads P0, 0001 loads P1, 0010 loads the stride, 1110 loads the lower bound and 1111 loads the upper bound, each from `rf_data`.
- R3: Codes 0011, 1100 and 1101 change no register. `addr` keeps its value and `addr_vld` goes low.
- R4: Code 0100 puts `imm` on `addr`, and code 0101 puts `rf_data` on `addr`.
- R5: Codes 0110 (P0) and 0111 (P1) put the current pointer on `addr`. The pointer then becomes pointer + stride.
- R6: Codes 1000 (P0) and 1001 (P1) put pointer + `imm` on `addr` and leave the pointer unchanged.
- R7: Codes 1010 (P0) and 1011 (P1) put the current pointer on `addr`. The pointer then loads the lower bound if pointer + 1 equals the upper bound; otherwise it becomes pointer + 1.
- R8: `addr` and `addr_vld` are registered, so they reflect the code presented at the previous enabled edge. `addr_vld` is 1 only for codes 0100 through 1011.
- R9: At an edge with `en` low and `rst` low, every register holds, including `addr` and `addr_vld`.
- R10: All additions wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation enable |
| op | input | 4 | Operation code |
| rf_data | input | W | Register-file data word |
| imm | input | W | Immediate field |
| addr | output | W | Registered data-memory address |
| addr_vld | output | 1 | Address valid flag |

## Verification
The address-producing codes are tried against distinct pointer values and against both pointers. The aim is to show that each code reaches the register it names and no other. The stride test gives two post-increment results from one run, and these tell an increment of one apart from an increment by the stride. Circular stepping runs right through the wrap point, starting one below and at the lower bound, which shows whether the wrap compare uses pointer + 1 or the pointer itself. Pointers near the top of the range separate wrapping arithmetic from anything that saturates. Reading back after no-operations and after disabled edges shows that neither touched state.

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] rf_data,
  input  logic [W-1:0] imm,
  output logic [W-1:0] addr,
  output logic         addr_vld
);

  logic [W-1:0] p0, p1, stride, lo_bnd, hi_bnd;
  logic [W-1:0] sel_p, sel_inc, sel_ring;
  logic         is_addr;

  assign sel_p    = op[0] ? p1 : p0;
  assign sel_inc  = sel_p + {{(W-1){1'b0}}, 1'b1};
  assign sel_ring = (sel_inc == hi_bnd) ? lo_bnd : sel_inc;
  assign is_addr  = (op >= 4'b0100) && (op <= 4'b1011);

  always_ff @(posedge clk) begin
    if (rst) begin
      p0 <= '0; p1 <= '0; stride <= '0; lo_bnd <= '0; hi_bnd <= '0;
      addr <= '0; addr_vld <= 1'b0;
    end else if (en) begin
      addr_vld <= is_addr;
      case (op)
        4'b0000: p0     <= rf_data;
        4'b0001: p1     <= rf_data;
        4'b0010: stride <= rf_data;
        4'b1110: lo_bnd <= rf_data;
        4'b1111: hi_bnd <= rf_data;
        4'b0100: addr   <= imm;
        4'b0101: addr   <= rf_data;
        4'b0110, 4'b0111: begin
          addr <= sel_p;
          if (op[0]) p1 <= sel_p + stride; else p0 <= sel_p + stride;
        end
        4'b1000, 4'b1001: addr <= sel_p + imm;
        4'b1010, 4'b1011: begin
          addr <= sel_p;
          if (op[0]) p1 <= sel_ring; else p0 <= sel_ring;
        end
        default: ;
      endcase
    end
  end

  assert_vld_code_R8: assert property (@(posedge clk) disable iff (rst)
    en |=> addr_vld == ($past(op) >= 4'd4 && $past(op) <= 4'd11));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(p0) && $stable(p1) && $stable(stride) && $stable(lo_bnd)
            && $stable(hi_bnd) && $stable(addr) && $stable(addr_vld));

  assert_nop_still_R3: assert property (@(posedge clk) disable iff (rst)
    en && (op == 4'b0011 || op == 4'b1100 || op == 4'b1101) |=>
      $stable(p0) && $stable(p1) && $stable(stride) && $stable(lo_bnd)
      && $stable(hi_bnd) && $stable(addr) && !addr_vld);

  assert_post_step_R5: assert property (@(posedge clk) disable iff (rst)
    en && op == 4'b0110 |=> addr == $past(p0) && p0 == $past(p0) + $past(stride));

  assert_index_keep_R6: assert property (@(posedge clk) disable iff (rst)
    en && op == 4'b1001 |=> $stable(p1) && addr == $past(p1) + $past(imm));

  assert_ring_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    en && op == 4'b1010 |=> addr == $past(p0) &&
      p0 == (($past(p0) + 1'b1 == $past(hi_bnd)) ? $past(lo_bnd) : $past(p0) + 1'b1));

endmodule

// File: tb/tb_addr_gen.sv
module tb_addr_gen;
  localparam int W = 16;
  logic clk = 0, rst = 1, en = 0;
  logic [3:0] op = 4'b0011;
  logic [W-1:0] rf_data = '0, imm = '0;
  logic [W-1:0] addr;
  logic addr_vld;
  int checks = 0, failures = 0;
  bit done = 0;

  addr_gen #(.W(W)) dut (.clk(clk), .rst(rst), .en(en), .op(op),
    .rf_data(rf_data), .imm(imm), .addr(addr), .addr_vld(addr_vld));

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] o, logic [W-1:0] rf, logic [W-1:0] im);
    @(negedge clk); en = 1; op = o; rf_data = rf; imm = im;
    @(posedge clk); #1;
  endtask

  task automatic read_p(bit which, logic [W-1:0] exp, string tag);
    issue(which ? 4'b1001 : 4'b1000, '0, '0);
    chk(tag, addr, exp);
    chk(tag, {{(W-1){1'b0}}, addr_vld}, 1);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1; en = 1; op = 4'b0100; imm = 16'h5555;
    @(posedge clk); #1;
    chk("R1 addr", addr, 0);
    chk("R1 vld", {15'b0, addr_vld}, 0);
    @(negedge clk); rst = 0;
    read_p(0, 0, "R1 p0");
    read_p(1, 0, "R1 p1");
  endtask

  task automatic t_direct;
    issue(4'b0100, 16'hAAAA, 16'h1234);
    chk("R4 imm", addr, 16'h1234);
    chk("R8 vld", {15'b0, addr_vld}, 1);
    issue(4'b0101, 16'hBEEF, 16'h0001);
    chk("R4 rf", addr, 16'hBEEF);
  endtask

  task automatic t_index;
    issue(4'b0000, 16'h0100, 0);
    chk("R8 load no vld", {15'b0, addr_vld}, 0);
    issue(4'b0001, 16'h0200, 0);
    issue(4'b1000, 0, 16'h0005); chk("R6 p0+imm", addr, 16'h0105);
    issue(4'b1001, 0, 16'h0010); chk("R6 p1+imm", addr, 16'h0210);
    read_p(0, 16'h0100, "R6 R2 p0 kept");
    read_p(1, 16'h0200, "R6 R2 p1 kept");
  endtask

  task automatic t_step;
    issue(4'b0010, 16'h0003, 0);
    issue(4'b0110, 0, 0); chk("R5 p0 first", addr, 16'h0100);
    issue(4'b0110, 0, 0); chk("R5 p0 second", addr, 16'h0103);
    read_p(0, 16'h0106, "R5 p0 after");
    issue(4'b0111, 0, 0); chk("R5 p1 first", addr, 16'h0200);
    read_p(1, 16'h0203, "R5 p1 after");
  endtask

  task automatic t_ring;
    issue(4'b1110, 16'h0040, 0);
    issue(4'b1111, 16'h0043, 0);
    issue(4'b0000, 16'h0041, 0);
    issue(4'b1010, 0, 0); chk("R7 p0 a", addr, 16'h0041);
    issue(4'b1010, 0, 0); chk("R7 p0 b", addr, 16'h0042);
    issue(4'b1010, 0, 0); chk("R7 p0 wrap", addr, 16'h0040);
    issue(4'b0001, 16'h0040, 0);
    for (int i = 0; i < 4; i++) begin
      issue(4'b1011, 0, 0);
      chk("R7 p1 ring", addr, (i == 3) ? 16'h0040 : 16'h0040 + i[15:0]);
    end
  endtask

  task automatic t_nop;
    issue(4'b0100, 0, 16'h7777);
    issue(4'b0011, 16'hFFFF, 16'hFFFF);
    chk("R3 vld low", {15'b0, addr_vld}, 0);
    chk("R3 addr hold", addr, 16'h7777);
    issue(4'b1100, 16'hFFFF, 0);
    issue(4'b1101, 16'hFFFF, 0);
    chk("R3 addr hold2", addr, 16'h7777);
    read_p(0, 16'h0041, "R3 p0 kept");
  endtask

  task automatic t_enable;
    issue(4'b0100, 0, 16'h4321);
    @(negedge clk); en = 0; op = 4'b0000; rf_data = 16'hFFFF; imm = 16'h1111;
    @(posedge clk); #1;
    chk("R9 addr hold", addr, 16'h4321);
    chk("R9 vld hold", {15'b0, addr_vld}, 1);
    @(negedge clk); op = 4'b0011;
    @(posedge clk); #1;
    chk("R9 vld hold2", {15'b0, addr_vld}, 1);
    read_p(0, 16'h0041, "R9 p0 kept");
  endtask

  task automatic t_wrap;
    issue(4'b0000, 16'hFFFF, 0);
    issue(4'b0010, 16'h0002, 0);
    issue(4'b1000, 0, 16'h0003); chk("R10 index wrap", addr, 16'h0002);
    issue(4'b0110, 0, 0); chk("R10 post addr", addr, 16'hFFFF);
    read_p(0, 16'h0001, "R10 step wrap");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset; t_direct; t_index; t_step; t_ring; t_nop; t_enable; t_wrap;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule